// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes to a smart card over a single half-duplex I/O line using the T=0 character protocol of ISO/IEC 7816-3. The host writes a byte into a one-deep holding register. On the next elementary time unit (ETU) tick the block shifts out a frame: a low start bit, the eight data bits least significant first, and an even parity bit. It then releases the line for a two-ETU guard window. The line is driven open-drain style: the block only ever pulls it low, and it idles released (high).

At the end of the first guard ETU the block samples the line. If the card holds it low there, this is an error signal. When such a frame ends, the error flag is set and the transmit-end flag stays clear. The same byte is then sent again as a fresh frame, starting on the very next ETU. A retry limit caps the number of resends. When the limit is used up, the byte is dropped and the holding register is freed. A frame that draws no error signal sets the transmit-end flag and frees the holding register. Two interrupt requests, each gated by its own enable, follow the two flags. ETU timing comes entirely from a clock-enable input.

Top module: `sc_char_tx`

## Requirements
- R1: After reset the holding register is empty (`buf_empty`=1), `tx_end`=1, `err_flag`=0, `drive_low`=0, and both interrupt requests are 0 when their enables are 0.
- R2: A frame lasts ten ETUs with the line driven as follows: ETU 0 is the start bit (line low, `drive_low`=1). ETUs 1..8 carry data bits D0..D7, least significant first. ETU 9 carries the parity bit, chosen so that D0..D7 plus parity hold an even number of ones. A 0 bit is sent as `drive_low`=1 and a 1 bit as `drive_low`=0. `drive_low` changes only at the clock edge that samples `etu_tick`=1.
- R3: `drive_low` is 0 during both guard ETUs that follow the parity bit, and whenever no frame is in progress.
- R4: If `line_in` is low when sampled at the end of the first guard ETU, then at the end of the second guard ETU `err_flag` becomes 1 and `tx_end` stays 0. The same byte is resent, and its start bit begins at that same tick, 12 ETUs after the previous start bit.
- R5: If `line_in` is high at that sample point, then at the end of the frame `tx_end` becomes 1, `buf_empty` becomes 1 and `err_flag` is left as it was.
- R6: A write (`wr_en`=1) while `buf_empty`=1 is accepted: `buf_empty` and `tx_end` go to 0 on the next cycle. A write while `buf_empty`=0 is ignored, so the byte in flight and any resend of it are unchanged.
- R7: A one-cycle pulse on `err_clr` clears `err_flag`. If a new error is recorded in the same cycle, the set wins.
- R8: With retry limit MAX_RETRY (default 3, at least 1), a byte whose original frame and all MAX_RETRY resends draw an error signal is dropped. At the end of the last frame, `err_flag`=1, `tx_end` stays 0, `buf_empty`=1, and no further frame starts until a new write.
- R9: `txi_req` is 1 exactly when `txi_en`=1 and `tx_end`=1. `eri_req` is 1 exactly when `eri_en`=1 and `err_flag`=1.
- R10: After a write, a frame begins only at an `etu_tick`. The holding register is freed only at an `etu_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle enable marking the end of each ETU |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| err_clr | input | 1 | Pulse that clears the error flag (host writes 0) |
| txi_en | input | 1 | Transmit-end interrupt enable |
| eri_en | input | 1 | Error interrupt enable |
| line_in | input | 1 | Sensed level of the I/O line |
| drive_low | output | 1 | 1 pulls the I/O line low, 0 releases it |
| buf_empty | output | 1 | Holding register is free for a new byte |
| tx_end | output | 1 | Last byte completed without an error signal |
| err_flag | output | 1 | An error signal was received |
| txi_req | output | 1 | Transmit interrupt request |
| eri_req | output | 1 | Error interrupt request |

## Verification
Fixed bytes and random bytes are each sent under three card behaviours:
- a card that accepts at once, which isolates the plain frame format, parity and completion flags;
- a card that rejects a few times before accepting, which shows that resends carry the identical byte 12 ETUs apart and that `tx_end` waits for the clean frame;
- a card that rejects every attempt, which separates correct dropping at the retry limit from an endless resend loop.

Writes issued mid-frame check that a busy holding register ignores them. Random interrupt enables check that the requests follow the flags.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    localparam int DATA_W       = 8;
    localparam int BIT_SLOTS    = DATA_W + 2;   // start, data, parity
    localparam int GUARD_ETUS   = 2;
    localparam int SAMPLE_GUARD = 0;            // guard ETU whose end samples the line
    localparam int SLOT_W       = $clog2(BIT_SLOTS);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BITS,
        PH_GUARD
    } phase_e;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_OK,
        OUT_RETRY,
        OUT_DROP
    } outcome_e;

    typedef struct packed {
        logic     valid;
        outcome_e kind;
    } frame_end_t;

    // Parity bit that makes the data plus parity hold an even count of ones.
    function automatic logic even_par(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction

    // Line level of one bit slot of the frame.
    function automatic logic slot_level(input int unsigned idx, input logic [DATA_W-1:0] d);
        if (idx == 0)
            return 1'b0;
        else if (idx <= DATA_W)
            return d[idx-1];
        else
            return even_par(d);
    endfunction

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b1;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign line_o = chain_q[STAGES-1];
endmodule

// File: rtl/sc_tx_holding.sv
module sc_tx_holding
    import sc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              release_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o,
    output logic              accept_o
);
    logic [DATA_W-1:0] data_q;
    logic              empty_q;

    assign accept_o = wr_en && empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (accept_o) begin
            data_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (release_i) begin
            empty_q <= 1'b1;
        end
    end

    assign data_o  = data_q;
    assign empty_o = empty_q;
endmodule

// File: rtl/sc_frame_seq.sv
module sc_frame_seq
    import sc_tx_pkg::*;
#(
    parameter int MAX_RETRY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              etu_tick,
    input  logic              pending_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              line_s,
    output logic              drive_low_o,
    output logic              in_guard_o,
    output frame_end_t        fin_o
);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);
    localparam logic [SLOT_W-1:0] LAST_BIT    = SLOT_W'(BIT_SLOTS - 1);
    localparam logic [SLOT_W-1:0] LAST_GUARD  = SLOT_W'(GUARD_ETUS - 1);
    localparam logic [SLOT_W-1:0] SAMPLE_SLOT = SLOT_W'(SAMPLE_GUARD);

    phase_e            phase_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] shreg_q;
    logic              err_seen_q;
    logic [RTY_W-1:0]  retry_q;

    // Outcome of the frame, decided on the tick that ends the last guard ETU.
    always_comb begin
        fin_o.valid = 1'b0;
        fin_o.kind  = OUT_NONE;
        if (etu_tick && phase_q == PH_GUARD && slot_q == LAST_GUARD) begin
            fin_o.valid = 1'b1;
            if (!err_seen_q)
                fin_o.kind = OUT_OK;
            else if (retry_q < RTY_W'(MAX_RETRY))
                fin_o.kind = OUT_RETRY;
            else
                fin_o.kind = OUT_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            slot_q     <= '0;
            shreg_q    <= '0;
            err_seen_q <= 1'b0;
            retry_q    <= '0;
        end else if (etu_tick) begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (pending_i) begin
                        phase_q    <= PH_BITS;
                        slot_q     <= '0;
                        shreg_q    <= data_i;
                        err_seen_q <= 1'b0;
                    end
                end
                PH_BITS: begin
                    if (slot_q == LAST_BIT) begin
                        phase_q <= PH_GUARD;
                        slot_q  <= '0;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                PH_GUARD: begin
                    if (slot_q == SAMPLE_SLOT)
                        err_seen_q <= ~line_s;
                    if (fin_o.valid) begin
                        slot_q <= '0;
                        if (fin_o.kind == OUT_RETRY) begin
                            phase_q    <= PH_BITS;
                            shreg_q    <= data_i;
                            err_seen_q <= 1'b0;
                            retry_q    <= retry_q + 1'b1;
                        end else begin
                            phase_q <= PH_IDLE;
                            retry_q <= '0;
                        end
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign drive_low_o = (phase_q == PH_BITS) && !slot_level(32'(slot_q), shreg_q);
    assign in_guard_o  = (phase_q == PH_GUARD);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
    import sc_tx_pkg::*;
#(
    parameter int MAX_RETRY   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              etu_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_clr,
    input  logic              txi_en,
    input  logic              eri_en,
    input  logic              line_in,
    output logic              drive_low,
    output logic              buf_empty,
    output logic              tx_end,
    output logic              err_flag,
    output logic              txi_req,
    output logic              eri_req
);
    logic              line_s;
    logic [DATA_W-1:0] hold_data;
    logic              hold_empty;
    logic              accept;
    logic              guard_phase;
    frame_end_t        fin;
    logic              release_hold;
    logic              tx_end_q;
    logic              err_q;

    sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_in),
        .line_o (line_s)
    );

    assign release_hold = fin.valid && (fin.kind != OUT_RETRY);

    sc_tx_holding u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .release_i (release_hold),
        .data_o    (hold_data),
        .empty_o   (hold_empty),
        .accept_o  (accept)
    );

    sc_frame_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .etu_tick    (etu_tick),
        .pending_i   (!hold_empty),
        .data_i      (hold_data),
        .line_s      (line_s),
        .drive_low_o (drive_low),
        .in_guard_o  (guard_phase),
        .fin_o       (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_end_q <= 1'b1;
            err_q    <= 1'b0;
        end else begin
            if (accept)
                tx_end_q <= 1'b0;
            else if (fin.valid && fin.kind == OUT_OK)
                tx_end_q <= 1'b1;

            if (fin.valid && (fin.kind == OUT_RETRY || fin.kind == OUT_DROP))
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
        end
    end

    assign buf_empty = hold_empty;
    assign tx_end    = tx_end_q;
    assign err_flag  = err_q;
    assign txi_req   = txi_en && tx_end_q;
    assign eri_req   = eri_en && err_q;
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
    input logic clk,
    input logic rst,
    input logic etu_tick,
    input logic wr_en,
    input logic err_clr,
    input logic buf_empty,
    input logic tx_end,
    input logic err_flag,
    input logic txi_req,
    input logic eri_req,
    input logic drive_low,
    input logic in_guard
);
    // R2: the line only moves on an ETU tick
    a_r2_drive_on_tick: assert property (@(posedge clk) disable iff (rst)
        !etu_tick |=> $stable(drive_low));

    // R3: line released in the guard window
    a_r3_guard_release: assert property (@(posedge clk) disable iff (rst)
        in_guard |-> !drive_low);

    // R4: an error frame never raises transmit-end
    a_r4_no_tend_on_err: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> !$rose(tx_end));

    // R6: accepted write occupies the register and clears transmit-end
    a_r6_write_accept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && buf_empty) |=> (!buf_empty && !tx_end));

    // R7: clear pulse away from a tick empties the error flag
    a_r7_err_clear: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !etu_tick) |=> !err_flag);

    // R9: requests only with their flag
    a_r9_txi_follows: assert property (@(posedge clk) disable iff (rst)
        txi_req |-> tx_end);
    a_r9_eri_follows: assert property (@(posedge clk) disable iff (rst)
        eri_req |-> err_flag);

    // R10: the register is freed only on a tick
    a_r10_free_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!buf_empty && !etu_tick) |=> !buf_empty);
endmodule

bind sc_char_tx sc_char_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .etu_tick  (etu_tick),
    .wr_en     (wr_en),
    .err_clr   (err_clr),
    .buf_empty (buf_empty),
    .tx_end    (tx_end),
    .err_flag  (err_flag),
    .txi_req   (txi_req),
    .eri_req   (eri_req),
    .drive_low (drive_low),
    .in_guard  (guard_phase)
);

// File: tb/sc_char_tx_bench.sv
module sc_char_tx_bench;
    localparam int ETU       = 16;
    localparam int MAX_RETRY = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       etu_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       err_clr = 1'b0;
    logic       txi_en = 1'b0;
    logic       eri_en = 1'b0;
    logic       card_low = 1'b0;
    logic       line_in;
    logic       drive_low, buf_empty, tx_end, err_flag, txi_req, eri_req;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int last_start = -1;

    assign line_in = !(drive_low || card_low);

    sc_char_tx #(.MAX_RETRY(MAX_RETRY)) u_sc_char_tx (
        .clk(clk), .rst(rst), .etu_tick(etu_tick), .wr_en(wr_en), .wr_data(wr_data),
        .err_clr(err_clr), .txi_en(txi_en), .eri_en(eri_en), .line_in(line_in),
        .drive_low(drive_low), .buf_empty(buf_empty), .tx_end(tx_end),
        .err_flag(err_flag), .txi_req(txi_req), .eri_req(eri_req)
    );

    always #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial begin
        forever begin
            repeat (ETU - 1) @(negedge clk);
            etu_tick = 1'b1;
            @(negedge clk);
            etu_tick = 1'b0;
        end
    end

    function automatic logic exp_parity(input logic [7:0] d);
        logic p = 1'b0;
        for (int i = 0; i < 8; i++) p = p ^ d[i];
        return p;
    endfunction

    // Holding register is freed after an error frame only when the retry limit is used up.
    function automatic logic exp_empty_after_err(input int attempt);
        return attempt == MAX_RETRY;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        logic seen = 1'b0;
        repeat (2 * ETU) begin
            @(negedge clk);
            if (drive_low) seen = 1'b1;
        end
        check(req, int'(seen), 0);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 accept empty", int'(buf_empty), 0);
        check("R6 accept tend", int'(tx_end), 0);
    endtask

    // Plays one frame as the card. On entry the block must be about to send or sending.
    task automatic run_frame(input logic [7:0] exp, input bit inject, input int attempt,
                             input bit poke_write);
        int rel;
        int waited;
        logic [7:0] got;
        logic pbit;
        waited = 0;
        while (!drive_low && waited < 40 * ETU) begin
            @(negedge clk);
            waited++;
        end
        if (!drive_low) begin
            check("R10 frame start timeout", 0, 1);
            return;
        end
        if (attempt > 0) check("R4 R10 resend spacing", cyc - last_start, 12 * ETU);
        last_start = cyc;
        check("R2 start bit", int'(drive_low), 1);
        rel = 0;
        err_clr = 1'b1;
        @(negedge clk); rel++;
        err_clr = 1'b0;
        check("R7 err cleared", int'(err_flag), 0);
        if (poke_write) begin
            @(negedge clk); rel++;
            wr_en = 1'b1;
            wr_data = ~exp;
            @(negedge clk); rel++;
            wr_en = 1'b0;
            check("R6 ignored write keeps busy", int'(buf_empty), 0);
        end
        repeat (7 - rel) @(negedge clk);
        got = '0;
        pbit = 1'b0;
        for (int i = 1; i <= 9; i++) begin
            repeat (ETU) @(negedge clk);
            if (i <= 8) got[i-1] = !drive_low;
            else begin
                pbit = !drive_low;
                if (inject) card_low = 1'b1;
            end
        end
        check("R2 R6 data bits", int'(got), int'(exp));
        check("R2 parity", int'(pbit), int'(exp_parity(exp)));
        repeat (ETU) @(negedge clk);
        check("R3 guard0 released", int'(drive_low), 0);
        repeat (ETU) @(negedge clk);
        check("R3 guard1 released", int'(drive_low), 0);
        card_low = 1'b0;
        repeat (ETU / 2 + 1) @(negedge clk);
        if (inject) begin
            check("R4 err set", int'(err_flag), 1);
            check("R4 no tend", int'(tx_end), 0);
            check("R8 empty after err", int'(buf_empty), int'(exp_empty_after_err(attempt)));
            check("R9 eri", int'(eri_req), int'(eri_en));
            check("R9 txi off", int'(txi_req), 0);
        end else begin
            check("R5 err stays clear", int'(err_flag), 0);
            check("R5 tend set", int'(tx_end), 1);
            check("R5 empty set", int'(buf_empty), 1);
            check("R9 txi", int'(txi_req), int'(txi_en));
            check("R9 eri off", int'(eri_req), 0);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input int nerr, input bit poke);
        int frames;
        write_byte(d);
        frames = (nerr > MAX_RETRY) ? MAX_RETRY + 1 : nerr + 1;
        for (int a = 0; a < frames; a++)
            run_frame(d, a < nerr, a, poke && a == 0);
        if (nerr > MAX_RETRY) idle_check("R8 no frame after drop");
        else                  idle_check("R3 idle released");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_7816));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 empty", int'(buf_empty), 1);
        check("R1 tend", int'(tx_end), 1);
        check("R1 err", int'(err_flag), 0);
        check("R1 line", int'(drive_low), 0);
        check("R1 irqs", int'({txi_req, eri_req}), 0);
        txi_en = 1'b1;
        @(negedge clk);
        check("R9 txi after reset", int'(txi_req), 1);

        // directed corners
        send_char(8'h00, 0, 1'b0);
        send_char(8'hFF, 1, 1'b1);
        eri_en = 1'b1;
        send_char(8'hA5, MAX_RETRY + 1, 1'b0);
        send_char(8'h01, MAX_RETRY, 1'b1);

        // random mix
        for (int n = 0; n < 14; n++) begin
            logic [7:0] d;
            int r;
            d = 8'($urandom);
            r = int'($urandom % 8);
            txi_en = 1'($urandom);
            eri_en = 1'($urandom);
            send_char(d, (r < 3) ? 0 : (r < 7) ? (r - 2) % (MAX_RETRY + 1) : MAX_RETRY + 1,
                      1'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule